// File: doc/BRIEF.md
# Serial Command Word Sender

This block is a serial peripheral bus master that writes one 16-bit word per request. A 4-bit command code and a 12-bit data value are presented together with a single-cycle send strobe. The block joins them into one word, with the command in the upper nibble, and shifts the word out most significant bit first. It drives an active-low chip select, a serial clock and a master-out data line. All timing comes from the system clock through counters set by parameters: a clock divider, a setup delay between the chip select falling and the first clock edge, and a minimum quiet gap after each frame.

The serial clock idles low. The peripheral samples on each rising edge, and the block changes its data line only on falling edges. `busy` stays high from the accepted request until the quiet gap has run out. `done` marks the end of the frame with a single-cycle pulse. A request made while the block is busy is not lost. It is kept in a one-entry slot and sent as soon as the gap ends. A later request made while a request is already waiting replaces the waiting one.

Top module: `spi_cmd_tx`

## Requirements
- R1: Each frame carries the word {cmdIn[3:0], dataIn[11:0]}. Bit 15 is the first bit on the wire and bit 0 the last. Exactly one bit is presented per rising serial clock edge, and each frame has exactly 16 rising edges.
- R2: `sck` is low whenever `csN` is high. `mosi` holds steady while `sck` is high. `mosi` already shows bit 15 in the first cycle that `csN` is low.
- R3: The serial clock period is 6 system clocks: 3 cycles high and 3 cycles low.
- R4: The first rising `sck` edge comes exactly 1 system clock after `csN` falls.
- R5: `csN` rises again one half period (3 cycles) after the 16th falling `sck` edge, which is 6 cycles after the 16th rising edge.
- R6: `done` is high for exactly one cycle: the first cycle in which `csN` is high again after a frame. It is low at all other times.
- R7: Between two frames, `csN` stays high for at least 32 system clocks. When the next request is already waiting, it stays high for exactly 32 clocks.
- R8: A strobe made while the block is idle starts a frame at the next clock edge, with `csN` low and `busy` high. After the frame, `busy` stays high for the 32 cycles starting with the cycle in which `csN` rises, and falls after them. While `busy` is low, `csN` is high and `sck` is low.
- R9: A strobe made while the block is busy is held in one slot and sent after the gap. If several strobes arrive while busy, only the last one is sent. No frame is lost and no frame is duplicated.
- R10: After reset, `csN` is 1, `sck` is 0, `mosi` is 0, `busy` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sendStb | input | 1 | Single-cycle request to send a word |
| cmdIn | input | 4 | Command code, sampled with sendStb |
| dataIn | input | 12 | Data value, sampled with sendStb |
| csN | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, MSB first |
| busy | output | 1 | High while a frame or its trailing gap is in progress |
| done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The hardest case to reach is a request that arrives during the trailing gap, and above all in its very last cycle. In that case the frame must start at the same edge at which the gap ends, and the chip select must stay high for exactly 32 clocks. The random stimulus waits until the previous frame has started and then issues the next request after a random delay of 0 to 100 cycles. These delays sweep the request across the frame body, the gap, the gap boundary and the idle period. Directed sequences add the fully back-to-back case and the case where a second waiting request replaces the first.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Sequencer states for one frame plus its trailing quiet gap
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } txState_e;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadWord;  // take the next word into the shifter
    logic shiftBit;  // advance the shifter by one bit
  } dpCtrl_t;

endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int SCK_DIV    = 6,
  parameter int SETUP_CLKS = 1,
  parameter int GAP_CLKS   = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sendStb,
  input  logic    pendValid,
  output dpCtrl_t dpCtrl,
  output logic    csN,
  output logic    sck,
  output logic    busy,
  output logic    done
);

  localparam int HALF  = SCK_DIV / 2;
  localparam int MAX_A = (HALF > SETUP_CLKS) ? HALF : SETUP_CLKS;
  localparam int MAX_C = (MAX_A > GAP_CLKS) ? MAX_A : GAP_CLKS;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] HALF_LOAD  = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD   = CNT_W'(GAP_CLKS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(WORD_W - 1);

  txState_e         state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [BIT_W-1:0] bitIdx, bitNxt;
  logic             csNxt, sckNxt, busyNxt, doneNxt;
  logic             startReq, cntZero;

  assign startReq = sendStb | pendValid;
  assign cntZero  = (cnt == '0);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    bitNxt   = bitIdx;
    csNxt    = csN;
    sckNxt   = sck;
    busyNxt  = busy;
    doneNxt  = 1'b0;
    dpCtrl   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNxt        = ST_SETUP;
          cntNxt          = SETUP_LOAD;
          bitNxt          = '0;
          csNxt           = 1'b0;
          busyNxt         = 1'b1;
          dpCtrl.loadWord = 1'b1;
        end
      end
      ST_SETUP: begin
        if (cntZero) begin
          stateNxt = ST_HIGH;
          sckNxt   = 1'b1;
          cntNxt   = HALF_LOAD;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_HIGH: begin
        if (cntZero) begin
          stateNxt        = ST_LOW;
          sckNxt          = 1'b0;
          cntNxt          = HALF_LOAD;
          dpCtrl.shiftBit = (bitIdx != LAST_BIT);
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_LOW: begin
        if (cntZero) begin
          if (bitIdx == LAST_BIT) begin
            stateNxt = ST_GAP;
            csNxt    = 1'b1;
            doneNxt  = 1'b1;
            cntNxt   = GAP_LOAD;
            bitNxt   = '0;
          end else begin
            stateNxt = ST_HIGH;
            sckNxt   = 1'b1;
            cntNxt   = HALF_LOAD;
            bitNxt   = bitIdx + 1'b1;
          end
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_GAP: begin
        if (cntZero) begin
          if (startReq) begin
            stateNxt        = ST_SETUP;
            cntNxt          = SETUP_LOAD;
            csNxt           = 1'b0;
            dpCtrl.loadWord = 1'b1;
          end else begin
            stateNxt = ST_IDLE;
            busyNxt  = 1'b0;
          end
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      default: begin
        stateNxt = ST_IDLE;
        csNxt    = 1'b1;
        sckNxt   = 1'b0;
        busyNxt  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      csN    <= 1'b1;
      sck    <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      bitIdx <= bitNxt;
      csN    <= csNxt;
      sck    <= sckNxt;
      busy   <= busyNxt;
      done   <= doneNxt;
    end
  end

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sendStb,
  input  logic [CMD_W-1:0]  cmdIn,
  input  logic [DATA_W-1:0] dataIn,
  input  dpCtrl_t           dpCtrl,
  output logic              mosi,
  output logic              pendValid
);

  localparam int WORD_W = CMD_W + DATA_W;

  logic [WORD_W-1:0] packIn;
  logic [WORD_W-1:0] pendWord;
  logic [WORD_W-1:0] shreg;

  // Command occupies the upper bits so it leaves the wire first
  assign packIn = {cmdIn, dataIn};
  assign mosi   = shreg[WORD_W-1];

  // One-entry waiting slot: an older waiting word goes out before a new strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord  <= '0;
      pendValid <= 1'b0;
    end else if (dpCtrl.loadWord) begin
      pendValid <= pendValid & sendStb;
      if (pendValid && sendStb) pendWord <= packIn;
    end else if (sendStb) begin
      pendWord  <= packIn;
      pendValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg <= '0;
    end else if (dpCtrl.loadWord) begin
      shreg <= pendValid ? pendWord : packIn;
    end else if (dpCtrl.shiftBit) begin
      shreg <= {shreg[WORD_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx
  import spi_cmd_pkg::*;
#(
  parameter int CMD_W      = 4,
  parameter int DATA_W     = 12,
  parameter int SCK_DIV    = 6,
  parameter int SETUP_CLKS = 1,
  parameter int GAP_CLKS   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sendStb,
  input  logic [CMD_W-1:0]  cmdIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done
);

  localparam int WORD_W = CMD_W + DATA_W;

  dpCtrl_t dpCtrl;
  logic    pendValid;

  spi_cmd_ctrl #(
    .WORD_W(WORD_W),
    .SCK_DIV(SCK_DIV),
    .SETUP_CLKS(SETUP_CLKS),
    .GAP_CLKS(GAP_CLKS)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sendStb(sendStb),
    .pendValid(pendValid),
    .dpCtrl(dpCtrl),
    .csN(csN),
    .sck(sck),
    .busy(busy),
    .done(done)
  );

  spi_cmd_dp #(
    .CMD_W(CMD_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .sendStb(sendStb),
    .cmdIn(cmdIn),
    .dataIn(dataIn),
    .dpCtrl(dpCtrl),
    .mosi(mosi),
    .pendValid(pendValid)
  );

endmodule

// File: rtl/spi_cmd_tx_chk.sv
module spi_cmd_tx_chk #(
  parameter int WORD_W   = 16,
  parameter int GAP_CLKS = 32
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic mosi,
  input logic busy,
  input logic done
);

  localparam int HC_W = $clog2(GAP_CLKS + 1);
  localparam int RC_W = $clog2(WORD_W + 1);

  logic [HC_W-1:0] hiCnt;
  logic [RC_W-1:0] riseCnt;
  logic            sckQ;

  // Cycles with chip select high, saturating at the gap length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= HC_W'(GAP_CLKS);
    end else if (!csN) begin
      hiCnt <= '0;
    end else if (hiCnt < HC_W'(GAP_CLKS)) begin
      hiCnt <= hiCnt + 1'b1;
    end
  end

  // Rising serial clock edges seen in the current frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ    <= 1'b0;
      riseCnt <= '0;
    end else begin
      sckQ <= sck;
      if (csN) riseCnt <= '0;
      else if (sck && !sckQ) riseCnt <= riseCnt + 1'b1;
    end
  end

  p_bits_per_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> riseCnt == RC_W'(WORD_W));

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sck) |-> $stable(mosi));

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  p_setup_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sck);

  p_setup_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> sck);

  p_done_on_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(csN));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_gap_min_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> hiCnt >= HC_W'(GAP_CLKS));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && !sck));

endmodule

bind spi_cmd_tx spi_cmd_tx_chk #(
  .WORD_W(CMD_W + DATA_W),
  .GAP_CLKS(GAP_CLKS)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .csN(csN),
  .sck(sck),
  .mosi(mosi),
  .busy(busy),
  .done(done)
);

// File: tb/spi_cmd_tx_test.sv
module spi_cmd_tx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sendStb = 1'b0;
  logic [3:0]  cmdIn = '0;
  logic [11:0] dataIn = '0;
  logic        csN, sck, mosi, busy, done;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int starts = 0;
  int framesDone = 0;
  int lastGap = 0;
  bit finished = 0;
  logic [15:0] expQ[$];

  always #5 clk = ~clk;

  spi_cmd_tx uut (
    .clk(clk), .rstN(rstN), .sendStb(sendStb), .cmdIn(cmdIn), .dataIn(dataIn),
    .csN(csN), .sck(sck), .mosi(mosi), .busy(busy), .done(done)
  );

  function automatic logic [15:0] packWord(logic [3:0] c, logic [11:0] d);
    return {c, d};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Request pulse; push marks that this word is expected on the wire
  task automatic pulse(logic [3:0] c, logic [11:0] d, bit push);
    @(negedge clk);
    cmdIn = c;
    dataIn = d;
    sendStb = 1'b1;
    if (push) begin
      expQ.push_back(packWord(c, d));
      sent++;
    end
    @(negedge clk);
    sendStb = 1'b0;
  endtask

  task automatic waitStarted();
    while (starts < sent) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy !== 1'b0 || starts < sent) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Frame monitor, sampling between clock edges
  logic prevCs = 1'b1, prevSck = 1'b0, prevMosi = 1'b0;
  logic [15:0] word, expW;
  int cyc, bits, firstRise, lastRise, gapSamples = 1000;
  bit periodOk;

  always @(negedge clk) begin
    if (rstN) begin
      check(!(csN && sck), "R2", "sck high with csN high", sck, 0);
      if (done) check(csN && !prevCs, "R6", "done outside release cycle", {prevCs, csN}, 2'b01);
      if (sck && prevSck && !csN) check(mosi == prevMosi, "R2", "mosi moved while sck high", mosi, prevMosi);
      if (!csN && prevCs) begin
        starts++;
        if (expQ.size() == 0) begin
          check(0, "R9", "frame without request", 0, 1);
          expW = '0;
        end else begin
          expW = expQ.pop_front();
        end
        check(sck == 1'b0, "R4", "sck low at csN fall", sck, 0);
        check(mosi == expW[15], "R2", "first bit ready at csN fall", mosi, expW[15]);
        if (framesDone > 0) begin
          check(gapSamples >= 32, "R7", "gap between frames", gapSamples, 32);
          lastGap = gapSamples;
        end
        cyc = 0; bits = 0; word = '0; firstRise = -1; lastRise = 0; periodOk = 1;
      end else if (!csN) begin
        cyc++;
      end
      if (!csN && sck && !prevSck) begin
        word = {word[14:0], mosi};
        if (bits == 0) firstRise = cyc;
        else if (cyc - lastRise != 6) periodOk = 0;
        lastRise = cyc;
        bits++;
      end
      if (csN && !prevCs) begin
        check(bits == 16, "R1", "rising edges per frame", bits, 16);
        check(word == expW, "R1", "received word", word, expW);
        check(firstRise == 1, "R4", "setup delay", firstRise, 1);
        check(periodOk, "R3", "sck period of 6", periodOk, 1);
        check(cyc - lastRise == 5, "R5", "csN release after last bit", cyc - lastRise, 5);
        check(done == 1'b1, "R6", "done at release", done, 1);
        framesDone++;
        gapSamples = 1;
      end else if (csN) begin
        gapSamples++;
      end
      prevCs = csN; prevSck = sck; prevMosi = mosi;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R8", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(csN === 1'b1 && sck === 1'b0 && mosi === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R10", "reset state", {csN, sck, mosi, busy, done}, 5'b10000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R8: start from idle, then busy through the gap
    pulse(4'h9, 12'h3C6, 1);
    check(csN == 1'b0 && busy == 1'b1, "R8", "start after idle strobe", {csN, busy}, 2'b01);
    while (csN == 1'b0) @(negedge clk);
    n = 0;
    while (busy == 1'b1 && n < 100) begin n++; @(negedge clk); end
    check(n == 32, "R8", "busy cycles after csN rise", n, 32);
    check(csN == 1'b1 && sck == 1'b0, "R8", "idle outputs", {csN, sck}, 2'b10);

    // R1 corner words
    pulse(4'h0, 12'h000, 1); waitIdle();
    pulse(4'hF, 12'hFFF, 1); waitIdle();
    pulse(4'hA, 12'h5A5, 1); waitIdle();
    pulse(4'hF, 12'h000, 1); waitIdle();

    // R7/R9: request waiting during a frame goes out after exactly 32 clocks
    pulse(4'h1, 12'h234, 1);
    repeat (20) @(negedge clk);
    pulse(4'h5, 12'h678, 1);
    waitIdle();
    check(lastGap == 32, "R7", "back-to-back gap", lastGap, 32);

    // R9: second waiting request replaces the first
    pulse(4'h2, 12'h111, 1);
    repeat (10) @(negedge clk);
    pulse(4'h3, 12'h222, 0);
    repeat (5) @(negedge clk);
    pulse(4'h4, 12'h333, 1);
    waitIdle();
    check(expQ.size() == 0 && starts == sent, "R9", "only latest waiting word sent", starts, sent);

    // Random requests across frame, gap, boundary and idle
    for (int i = 0; i < 40; i++) begin
      logic [3:0]  c = 4'($urandom);
      logic [11:0] d = 12'($urandom);
      if ($urandom_range(0, 3) == 0) waitIdle();
      repeat ($urandom_range(0, 100)) @(negedge clk);
      pulse(c, d, 1);
      waitStarted();
    end
    waitIdle();
    check(expQ.size() == 0, "R9", "all random requests delivered", expQ.size(), 0);
    check(framesDone == sent, "R1", "frame count", framesDone, sent);
    check(busy == 1'b0 && done == 1'b0, "R6", "quiet at end", {busy, done}, 2'b00);
    report();
  end

endmodule